// File: doc/BRIEF.md
# Calendar RTC register interface

A word-addressed register block for a real-time clock, reached over a simple 32-bit request bus. It holds a packed time-of-day word (with weekday), a packed date word, a control word that reports which calendar words software has rewritten, and a small bank of scratch words. A one-cycle tick pulse, normally once per second, advances the calendar in place.

Software sets the clock by writing the date and time words. Each such write leaves a sticky pending flag in the control word. A read of the control word returns those flags and clears them in the same access, so software sees each rewrite exactly once. At reset the control word and scratch words clear. When the configured base year is above 1900, the date and time words load a preset taken from input ports. Reads return data one cycle after they are accepted.

Top module: `rtc_regblk`

## Requirements
- R1: After reset the control word and every scratch word read 0. The date and time words read the preset port values when BASE_YEAR > 1900, and 0 otherwise.
- R2: A read accepted in cycle n gives rvalid_o high with the data in cycle n+1. rvalid_o is low in every cycle that does not follow an accepted read.
- R3: Writing the date word (offset 0x04) stores the value and sets control bit 7. Writing the time word (offset 0x08) stores the value and sets control bit 8.
- R4: A read of the control word (offset 0x00) returns bits 7 and 8 as they stood before the access, then clears both. All other control bits read 0.
- R5: A write to the control word has no effect: it neither sets nor clears a flag.
- R6: The time word holds the weekday in [31:29], the hour in [20:16], the minute in [15:8] and the second in [7:0]. On a tick the second increments. A second at 59 or above wraps to 0 and carries into the minute, which wraps the same way and carries into the hour, and the hour wraps at 23.
- R7: When the hour wraps, the weekday advances (6 wraps to 0) and the date advances. The date word holds the year offset in [31:16], the month in [15:8] and the day in [7:0]. The day wraps from 31 (MONTH_DAYS) to 1 and carries into the month. The month wraps from 12 to 1 and carries into the year.
- R8: A bus write to the date or time word in the same cycle as a tick stores the written value for that word. The other word still takes its tick update.
- R9: Scratch word i sits at offset 0x20 + 4*i and returns the last value written to it. A write to one scratch word leaves the others unchanged.
- R10: A read of an unassigned offset, an unaligned offset or an offset at or above 0x400 returns 0. A write to any of these changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle calendar advance pulse |
| preset_date_i | input | 32 | Date word loaded at reset |
| preset_time_i | input | 32 | Time word loaded at reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench builds the main instance with BASE_YEAR = 2010, MONTH_DAYS = 31, four scratch words and a 12-bit offset. The 12-bit offset lets the bench reach offsets past the 1 KiB window, including one that aliases a scratch word when its upper bits are dropped. A second instance with BASE_YEAR = 1900 shares the bus and shows the preset being suppressed. The preset puts the calendar at the last second of a year on a Sunday, so the first tick runs every carry at once. Later writes place the calendar at month and year edges and at weekday 6.

// File: rtl/rtc_regblk_pkg.sv
package rtc_regblk_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_DATE,
    SEL_TIME,
    SEL_GP
  } sel_e;

  // control flag positions, decoded by software
  localparam int FLAG_DATE_BIT = 7;
  localparam int FLAG_TIME_BIT = 8;

  // fixed register offsets
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_DATE = 'h04;
  localparam int OFF_TIME = 'h08;
endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
  import rtc_regblk_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WINDOW_BYTES = 1024,
  parameter int GP_BASE      = 'h20,
  parameter int NUM_GP       = 4,
  parameter int GP_IDX_W     = 2
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output sel_e                sel_o,
  output logic [GP_IDX_W-1:0] gp_idx_o
);
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(WINDOW_BYTES);
  localparam logic [ADDR_W-1:0] GP_LO   = ADDR_W'(GP_BASE);
  localparam logic [ADDR_W-1:0] GP_HI   = ADDR_W'(GP_BASE + 4 * NUM_GP);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(OFF_DATE);
  localparam logic [ADDR_W-1:0] A_TIME  = ADDR_W'(OFF_TIME);

  logic aligned, in_win;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_win  = (addr_i < WIN_END);

  always_comb begin
    sel_o    = SEL_NONE;
    gp_idx_o = '0;
    if (aligned && in_win) begin
      if (addr_i == A_CTRL)      sel_o = SEL_CTRL;
      else if (addr_i == A_DATE) sel_o = SEL_DATE;
      else if (addr_i == A_TIME) sel_o = SEL_TIME;
      else if (addr_i >= GP_LO && addr_i < GP_HI) begin
        sel_o    = SEL_GP;
        gp_idx_o = GP_IDX_W'((addr_i - GP_LO) >> 2);
      end
    end
  end
endmodule

// File: rtl/rtc_field_step.sv
module rtc_field_step #(
  parameter int W     = 8,
  parameter int LIMIT = 59,
  parameter int FLOOR = 0
) (
  input  logic [W-1:0] val_i,
  input  logic         step_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  localparam logic [W-1:0] FLR = W'(FLOOR);

  logic at_top;
  assign at_top  = (val_i >= LIM);
  assign carry_o = step_i && at_top;

  always_comb begin
    if (!step_i)     val_o = val_i;
    else if (at_top) val_o = FLR;
    else             val_o = val_i + W'(1);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_regblk_pkg::*;
#(
  parameter int BASE_YEAR  = 2010,
  parameter int MONTH_DAYS = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] preset_date_i,
  input  logic [WORD_W-1:0] preset_time_i,
  input  logic              wr_date_i,
  input  logic              wr_time_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] date_o,
  output logic [WORD_W-1:0] time_o
);
  localparam bit LOAD_PRESET = (BASE_YEAR > 1900);

  logic [WORD_W-1:0] date_q, time_q, date_nxt, time_nxt;
  logic [7:0]  sec_n, min_n, day_n, mon_n;
  logic [4:0]  hr_n;
  logic [2:0]  wd_n;
  logic [15:0] yr_n;
  logic c_sec, c_min, c_hr, c_day, c_mon, c_wd, c_yr;

  rtc_field_step #(.W(8), .LIMIT(59), .FLOOR(0)) u_sec (
    .val_i(time_q[7:0]), .step_i(tick_i), .val_o(sec_n), .carry_o(c_sec));
  rtc_field_step #(.W(8), .LIMIT(59), .FLOOR(0)) u_min (
    .val_i(time_q[15:8]), .step_i(c_sec), .val_o(min_n), .carry_o(c_min));
  rtc_field_step #(.W(5), .LIMIT(23), .FLOOR(0)) u_hr (
    .val_i(time_q[20:16]), .step_i(c_min), .val_o(hr_n), .carry_o(c_hr));
  rtc_field_step #(.W(3), .LIMIT(6), .FLOOR(0)) u_wd (
    .val_i(time_q[31:29]), .step_i(c_hr), .val_o(wd_n), .carry_o(c_wd));
  rtc_field_step #(.W(8), .LIMIT(MONTH_DAYS), .FLOOR(1)) u_day (
    .val_i(date_q[7:0]), .step_i(c_hr), .val_o(day_n), .carry_o(c_day));
  rtc_field_step #(.W(8), .LIMIT(12), .FLOOR(1)) u_mon (
    .val_i(date_q[15:8]), .step_i(c_day), .val_o(mon_n), .carry_o(c_mon));
  rtc_field_step #(.W(16), .LIMIT(65535), .FLOOR(0)) u_yr (
    .val_i(date_q[31:16]), .step_i(c_mon), .val_o(yr_n), .carry_o(c_yr));

  assign time_nxt = {wd_n, time_q[28:21], hr_n, min_n, sec_n};
  assign date_nxt = {yr_n, mon_n, day_n};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      date_q <= LOAD_PRESET ? preset_date_i : '0;
      time_q <= LOAD_PRESET ? preset_time_i : '0;
    end else begin
      date_q <= wr_date_i ? wdata_i : date_nxt;  // bus write beats tick
      time_q <= wr_time_i ? wdata_i : time_nxt;
    end
  end

  assign date_o = date_q;
  assign time_o = time_q;

  p_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_time_i |=> time_q == $past(wdata_i));
  p_date_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_date_i |=> date_q == $past(wdata_i));
  p_sec_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_time_i && time_q[7:0] >= 8'd59) |=> time_q[7:0] == 8'd0);
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_time_i && !wr_date_i) |=> ($stable(time_q) && $stable(date_q)));
  p_midnight_day_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_date_i && time_q[20:0] == {5'd23, 8'd59, 8'd59}
     && date_q[7:0] < 8'(MONTH_DAYS)) |=> date_q[7:0] == $past(date_q[7:0]) + 8'd1);
endmodule

// File: rtl/rtc_scratch.sv
module rtc_scratch
  import rtc_regblk_pkg::*;
#(
  parameter int NUM_GP   = 4,
  parameter int GP_IDX_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [GP_IDX_W-1:0] idx_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o
);
  logic [WORD_W-1:0] slot_q [NUM_GP];

  for (genvar i = 0; i < NUM_GP; i++) begin : g_slot
    logic hit;
    assign hit = we_i && (idx_i == GP_IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  slot_q[i] <= '0;
      else if (hit) slot_q[i] <= wdata_i;
    end

    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && idx_i == GP_IDX_W'(i)) |=> $stable(slot_q[i]));
  end

  assign rdata_o = slot_q[idx_i];
endmodule

// File: rtl/rtc_regblk.sv
module rtc_regblk
  import rtc_regblk_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WINDOW_BYTES = 1024,
  parameter int GP_BASE      = 'h20,
  parameter int NUM_GP       = 4,
  parameter int BASE_YEAR    = 2010,
  parameter int MONTH_DAYS   = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [31:0]       preset_date_i,
  input  logic [31:0]       preset_time_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  localparam int GP_IDX_W = (NUM_GP > 1) ? $clog2(NUM_GP) : 1;

  sel_e                sel;
  logic [GP_IDX_W-1:0] gp_idx;
  logic                rd_acc, wr_acc;
  logic                date_pend_q, time_pend_q;
  logic [WORD_W-1:0]   date_w, time_w, gp_rdata, ctrl_w, rd_mux;
  logic [WORD_W-1:0]   rdata_q;
  logic                rvalid_q;

  assign rd_acc = req_i && !we_i;
  assign wr_acc = req_i && we_i;

  rtc_addr_decode #(
    .ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES), .GP_BASE(GP_BASE),
    .NUM_GP(NUM_GP), .GP_IDX_W(GP_IDX_W)
  ) u_dec (
    .addr_i(addr_i), .sel_o(sel), .gp_idx_o(gp_idx));

  rtc_calendar #(.BASE_YEAR(BASE_YEAR), .MONTH_DAYS(MONTH_DAYS)) u_cal (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .preset_date_i(preset_date_i), .preset_time_i(preset_time_i),
    .wr_date_i(wr_acc && sel == SEL_DATE),
    .wr_time_i(wr_acc && sel == SEL_TIME),
    .wdata_i(wdata_i), .date_o(date_w), .time_o(time_w));

  rtc_scratch #(.NUM_GP(NUM_GP), .GP_IDX_W(GP_IDX_W)) u_gp (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_acc && sel == SEL_GP),
    .idx_i(gp_idx), .wdata_i(wdata_i), .rdata_o(gp_rdata));

  // sticky flags: set by calendar writes, cleared by a control read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      date_pend_q <= 1'b0;
      time_pend_q <= 1'b0;
    end else begin
      if (wr_acc && sel == SEL_DATE)      date_pend_q <= 1'b1;
      else if (rd_acc && sel == SEL_CTRL) date_pend_q <= 1'b0;
      if (wr_acc && sel == SEL_TIME)      time_pend_q <= 1'b1;
      else if (rd_acc && sel == SEL_CTRL) time_pend_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_w = '0;
    ctrl_w[FLAG_DATE_BIT] = date_pend_q;
    ctrl_w[FLAG_TIME_BIT] = time_pend_q;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = ctrl_w;
      SEL_DATE: rd_mux = date_w;
      SEL_TIME: rd_mux = time_w;
      SEL_GP:   rd_mux = gp_rdata;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_rvalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> rvalid_o);
  p_no_rvalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |=> !rvalid_o);
  p_date_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && addr_i == ADDR_W'(OFF_DATE)) |=> date_pend_q);
  p_time_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && addr_i == ADDR_W'(OFF_TIME)) |=> time_pend_q);
  p_flag_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && addr_i == ADDR_W'(OFF_CTRL)) |=> (!date_pend_q && !time_pend_q));
  p_ctrl_other_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_acc && addr_i == ADDR_W'(OFF_CTRL)) |->
      (rdata_o & ~(32'h1 << FLAG_DATE_BIT | 32'h1 << FLAG_TIME_BIT)) == 32'h0);
  p_ctrl_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && sel == SEL_CTRL) |=> ($stable(date_pend_q) && $stable(time_pend_q)));
  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && sel == SEL_NONE) |=> rdata_o == 32'h0);
endmodule

// File: tb/rtc_regblk_tb.sv
module rtc_regblk_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] pdate, ptime;
  logic [31:0] rdata, rdata_b;
  logic        rvalid, rvalid_b;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [31:0] mk_time(int wd, int h, int m, int s);
    return {3'(wd), 8'd0, 5'(h), 8'(m), 8'(s)};
  endfunction
  function automatic logic [31:0] mk_date(int y, int mo, int d);
    return {16'(y), 8'(mo), 8'(d)};
  endfunction

  rtc_regblk #(.BASE_YEAR(2010)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .preset_date_i(pdate),
    .preset_time_i(ptime), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid));

  rtc_regblk #(.BASE_YEAR(1900)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .preset_date_i(pdate),
    .preset_time_i(ptime), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_b), .rvalid_o(rvalid_b));

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads as rvalid arrives
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected rvalid", rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata === e, t, rdata, e);
      end
    end
  end

  task automatic bus_wr(logic [11:0] a, logic [31:0] d, bit tk = 1'b0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; tick = tk;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, logic [31:0] e, string t);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    pdate = mk_date(14, 12, 31);
    ptime = mk_time(6, 23, 59, 59);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(12'h000, 32'h0, "R1 ctrl after reset");
    bus_rd(12'h004, pdate, "R1 date preset");
    chk(rvalid_b && rdata_b == 32'h0, "R1 no preset at base 1900", rdata_b, 32'h0);
    @(negedge clk);
    chk(rvalid == 1'b0, "R2 rvalid single pulse", {31'd0, rvalid}, 32'h0);
    bus_rd(12'h008, ptime, "R1 time preset");
    bus_rd(12'h020, 32'h0, "R1 scratch after reset");

    // R6 R7 full carry from preset
    do_tick();
    bus_rd(12'h008, mk_time(0, 0, 0, 0), "R6 R7 time full rollover");
    bus_rd(12'h004, mk_date(15, 1, 1), "R7 date year rollover");

    // R3 R4 time flag, minute carry
    bus_wr(12'h008, mk_time(2, 10, 59, 59));
    do_tick();
    bus_rd(12'h008, mk_time(2, 11, 0, 0), "R6 minute/hour carry");
    bus_rd(12'h000, 32'h100, "R3 time flag");
    bus_rd(12'h000, 32'h0, "R4 flags cleared");
    do_tick();
    bus_rd(12'h008, mk_time(2, 11, 0, 1), "R6 plain second");

    // midnight mid-month
    bus_wr(12'h004, mk_date(5, 3, 15));
    bus_wr(12'h008, mk_time(3, 23, 59, 59));
    bus_rd(12'h000, 32'h180, "R3 both flags");
    bus_rd(12'h000, 32'h0, "R4 both cleared");
    do_tick();
    bus_rd(12'h004, mk_date(5, 3, 16), "R7 day increment");
    bus_rd(12'h008, mk_time(4, 0, 0, 0), "R7 weekday advance");

    // month end
    bus_wr(12'h004, mk_date(5, 6, 31));
    bus_wr(12'h008, mk_time(6, 23, 59, 59));
    do_tick();
    bus_rd(12'h004, mk_date(5, 7, 1), "R7 month carry");
    bus_rd(12'h008, mk_time(0, 0, 0, 0), "R7 weekday 6 wraps");

    // R5 control writes ignored
    bus_rd(12'h000, 32'h180, "R4 flags before ctrl write");
    bus_wr(12'h000, 32'hFFFF_FFFF);
    bus_rd(12'h000, 32'h0, "R5 ctrl write sets nothing");
    bus_wr(12'h004, mk_date(5, 12, 31));
    bus_wr(12'h000, 32'h0);
    bus_rd(12'h000, 32'h080, "R5 ctrl write clears nothing");

    // R8 write beats tick
    bus_wr(12'h008, mk_time(1, 2, 3, 4), 1'b1);
    bus_rd(12'h008, mk_time(1, 2, 3, 4), "R8 time write wins");
    bus_wr(12'h008, mk_time(0, 23, 59, 59));
    bus_wr(12'h004, mk_date(9, 9, 9), 1'b1);
    bus_rd(12'h004, mk_date(9, 9, 9), "R8 date write wins");
    bus_rd(12'h008, mk_time(1, 0, 0, 0), "R8 time still ticks");
    bus_rd(12'h000, 32'h180, "R3 flags after concurrent writes");

    // R9 scratch
    for (int i = 0; i < 4; i++) bus_wr(12'(32 + 4 * i), 32'hA5A5_0000 + 32'(i));
    bus_wr(12'h024, 32'h1234_5678);
    for (int i = 0; i < 4; i++)
      bus_rd(12'(32 + 4 * i), (i == 1) ? 32'h1234_5678 : 32'hA5A5_0000 + 32'(i),
             "R9 scratch readback");

    // R10 unmapped
    bus_rd(12'h00C, 32'h0, "R10 hole reads 0");
    bus_rd(12'h400, 32'h0, "R10 out of window reads 0");
    bus_rd(12'h022, 32'h0, "R10 unaligned reads 0");
    bus_rd(12'h3FC, 32'h0, "R10 top of window reads 0");
    bus_wr(12'h424, 32'hDEAD_BEEF);
    bus_rd(12'h024, 32'h1234_5678, "R10 alias write ignored");
    bus_wr(12'h005, 32'h0BAD_0BAD);
    bus_rd(12'h004, mk_date(9, 9, 9), "R10 unaligned write ignored");
    bus_rd(12'h000, 32'h0, "R10 no flag from bad write");
    bus_wr(12'h010, 32'h5555_5555);
    bus_rd(12'h010, 32'h0, "R10 hole write ignored");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 reads all answered", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%08h exp=%08h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule